// File: doc/BRIEF.md
# Context Switch Sequencer for a Multi-Context Logic Array

This block keeps several complete configurations of a reconfigurable logic array in one shared single-port block RAM. On request, it copies one of them into the array's node registers. A configuration (a "context") takes `CFG_BITS` bits and is stored as `ceil(CFG_BITS / WORD_W)` consecutive RAM words. A context change is therefore a sequential transfer of one word per clock, not a single-cycle swap. Widening the RAM word shortens the transfer: with the default 5808-bit context, a 32-bit word needs 182 reads and a 128-bit word needs 46.

A host preloads contexts through a simple valid/ready write port that addresses the RAM by context number and word number. The RAM has only one port, so the sequencer arbitrates between host writes and its own reads. A switch in progress owns the RAM, and host writes wait until it ends. Each word read from the RAM is written to the array one cycle later, tagged with its word number. The unused top bits of the last word are cleared. A one-cycle done pulse marks the end of the transfer.

Top module: `ctx_switch_ctrl`

## Requirements
- R1: A RAM access for context `c`, word `w` uses address `c*WPC + w`, where `WPC = ceil(CFG_BITS/WORD_W)` (182 for 5808 bits at 32-bit words, 46 at 128-bit words).
- R2: A switch issues exactly `WPC` RAM reads, one per cycle, for words 0 to `WPC-1` in ascending order, and `sw_busy` stays high for exactly `WPC+1` cycles.
- R3: Each RAM read is followed in the next cycle by one array write: `arr_we` is high, `arr_idx` is the word number and `arr_data` is the word read.
- R4: In the last word of a context, the bits at positions `CFG_BITS-(WPC-1)*WORD_W` and above reach the array as zero. The other bits of that word, and all bits of every other word, pass through unchanged.
- R5: While `sw_busy` is high, `host_wr_ready` is low and no RAM write occurs. A held-off write is accepted once the switch ends.
- R6: A switch request made while `sw_busy` is high is ignored: the running transfer neither restarts nor changes context.
- R7: `sw_done` is high for exactly one cycle. That cycle directly follows the array write of the last word, and `sw_busy` is low in it.
- R8: When a switch request and a host write arrive in the same idle cycle, the switch wins: `host_wr_ready` is low in that cycle.
- R9: A host write whose word number is `WPC` or more is accepted (ready high) but performs no RAM access.
- R10: After reset, `sw_busy`, `sw_done`, `arr_we` and `ram_en` are low and `host_wr_ready` is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| sw_req | input | 1 | Request a context switch |
| sw_ctx | input | CTX_W | Context to load, sampled with `sw_req` |
| sw_busy | output | 1 | Switch transfer in progress |
| sw_done | output | 1 | One-cycle pulse at the end of a switch |
| host_wr_valid | input | 1 | Host write request |
| host_wr_ready | output | 1 | Host write accepted in this cycle when valid |
| host_wr_ctx | input | CTX_W | Context number of the host write |
| host_wr_word | input | WIDX_W | Word number inside the context |
| host_wr_data | input | WORD_W | Data to store |
| ram_en | output | 1 | RAM access enable |
| ram_we | output | 1 | RAM write (1) or read (0) |
| ram_addr | output | ADDR_W | RAM word address |
| ram_wdata | output | WORD_W | RAM write data |
| ram_rdata | input | WORD_W | RAM read data, valid one cycle after a read |
| arr_we | output | 1 | Array word write strobe |
| arr_idx | output | WIDX_W | Word number of the array write |
| arr_data | output | WORD_W | Configuration word for the array |

## Verification
On every cycle, the embedded assertions check these properties: array writes follow RAM reads with the same word number and in ascending order, the done pulse lasts one cycle right after the last word, the latched context stays fixed during a transfer, RAM addresses stay in range, and no host write reaches the RAM during a switch. The bench scenarios show the behaviours that need a memory image to check. Data arrives from the right context with its padding cleared. A write with an out-of-range word number leaves the next context intact. A request made mid-switch does not alter the data or the length of the transfer. A host write that collides with a switch lands only after the switch has delivered the old contents.

// File: rtl/ctxsw_pkg.sv
// Shared types and helpers for the context switch sequencer.
// Assumes: the users of the package compute every derived width from it.
package ctxsw_pkg;

    // Phase of the transfer sequencer
    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,
        ST_READ  = 2'd1,
        ST_DRAIN = 2'd2
    } seq_state_t;

    // Integer division rounded up, used for words per context
    function automatic int ceil_div(input int num, input int den);
        return (num + den - 1) / den;
    endfunction

endpackage

// File: rtl/ctxsw_addr_gen.sv
// Maps a (context, word) pair onto a flat RAM word address.
// Assumes: contexts are packed back to back, WPC words each, and the
// caller keeps the word number below WPC (or discards the access).
module ctxsw_addr_gen #(
    parameter int WPC    = 182,
    parameter int CTX_W  = 4,
    parameter int WIDX_W = 8,
    parameter int ADDR_W = 12
) (
    input  logic [CTX_W-1:0]  ctx,
    input  logic [WIDX_W-1:0] word,
    output logic [ADDR_W-1:0] addr
);

    // Base of the context plus offset of the word
    always_comb begin
        addr = ADDR_W'(ctx) * ADDR_W'(WPC) + ADDR_W'(word);
    end

endmodule

// File: rtl/ctxsw_pad.sv
// Clears the unused top bits of the last word of a context.
// Assumes: the padding is fewer than WORD_W bits, which holds because WPC is
// the rounded-up word count.
module ctxsw_pad #(
    parameter int WORD_W   = 32,
    parameter int PAD_BITS = 16
) (
    input  logic              is_last,
    input  logic [WORD_W-1:0] din,
    output logic [WORD_W-1:0] dout
);

    generate
        if (PAD_BITS == 0) begin : g_no_pad
            // Context fills its last word exactly: pass through
            always_comb dout = din;
            logic unused_last;
            assign unused_last = is_last;
        end else begin : g_pad
            localparam logic [WORD_W-1:0] KEEP = {WORD_W{1'b1}} >> PAD_BITS;
            // Mask the padding only on the last word
            always_comb dout = is_last ? (din & KEEP) : din;
        end
    endgenerate

endmodule

// File: rtl/ctxsw_arbiter.sv
// Shares the single RAM port between the switch sequencer and host writes.
// Assumes: a switch owns the port for its whole duration; while idle, a
// pending switch request takes precedence over a host write.
module ctxsw_arbiter #(
    parameter int NUM_CTX = 16,
    parameter int WPC     = 182,
    parameter int WORD_W  = 32,
    parameter int WIDX_W  = 8,
    parameter int ADDR_W  = 12
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              busy,
    input  logic              sw_req,
    output logic              start,
    input  logic              host_valid,
    output logic              host_ready,
    input  logic [WIDX_W-1:0] host_word,
    input  logic [ADDR_W-1:0] host_addr,
    input  logic [WORD_W-1:0] host_data,
    input  logic              rd_en,
    input  logic [ADDR_W-1:0] rd_addr,
    output logic              ram_en,
    output logic              ram_we,
    output logic [ADDR_W-1:0] ram_addr,
    output logic [WORD_W-1:0] ram_wdata
);

    logic word_ok;
    logic host_go;

    // Grant: switch first, host only when the port is free
    always_comb begin
        start      = sw_req && !busy;
        host_ready = !busy && !sw_req;
        word_ok    = int'(host_word) < WPC;
        host_go    = host_valid && host_ready && word_ok;
    end

    // Drive the RAM port from the current owner
    always_comb begin
        ram_en    = rd_en || host_go;
        ram_we    = host_go && !rd_en;
        ram_addr  = rd_en ? rd_addr : host_addr;
        ram_wdata = host_data;
    end

    AST_ADDR_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
        ram_en |-> (int'(ram_addr) < NUM_CTX * WPC)); // R1

    AST_NO_HOST_IN_SWITCH: assert property (@(posedge clk) disable iff (!rst_n)
        busy |-> !(ram_en && ram_we)); // R5

endmodule

// File: rtl/ctxsw_seq.sv
// Transfer sequencer: walks the words of one context, issues one RAM read
// per cycle and writes each returned word to the array a cycle later.
// Assumes: the RAM returns read data exactly one cycle after the address.
module ctxsw_seq
    import ctxsw_pkg::*;
#(
    parameter int WPC    = 182,
    parameter int CTX_W  = 4,
    parameter int WIDX_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start,
    input  logic [CTX_W-1:0]  start_ctx,
    output logic              busy,
    output logic              done,
    output logic              rd_en,
    output logic [CTX_W-1:0]  rd_ctx,
    output logic [WIDX_W-1:0] rd_word,
    output logic              arr_we,
    output logic [WIDX_W-1:0] arr_idx,
    output logic              arr_last
);

    localparam logic [WIDX_W-1:0] LAST_IDX = WIDX_W'(WPC - 1);

    seq_state_t        state;
    logic [CTX_W-1:0]  ctx_q;
    logic [WIDX_W-1:0] rd_idx;
    logic              vld_q;
    logic [WIDX_W-1:0] idx_q;
    logic              done_q;

    // Phase, latched context and read word counter
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state  <= ST_IDLE;
            ctx_q  <= '0;
            rd_idx <= '0;
        end else begin
            case (state)
                ST_IDLE: begin
                    if (start) begin
                        state  <= ST_READ;
                        ctx_q  <= start_ctx;
                        rd_idx <= '0;
                    end
                end
                ST_READ: begin
                    if (rd_idx == LAST_IDX) begin
                        state  <= ST_DRAIN;
                        rd_idx <= '0;
                    end else begin
                        rd_idx <= rd_idx + 1'b1;
                    end
                end
                ST_DRAIN: state <= ST_IDLE;
                default:  state <= ST_IDLE;
            endcase
        end
    end

    // One-cycle delay matching the RAM read latency
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            vld_q  <= 1'b0;
            idx_q  <= '0;
            done_q <= 1'b0;
        end else begin
            vld_q  <= (state == ST_READ);
            idx_q  <= rd_idx;
            done_q <= (state == ST_DRAIN);
        end
    end

    // Outputs toward the arbiter, the array and the handshake
    always_comb begin
        busy     = (state != ST_IDLE);
        done     = done_q;
        rd_en    = (state == ST_READ);
        rd_ctx   = ctx_q;
        rd_word  = rd_idx;
        arr_we   = vld_q;
        arr_idx  = idx_q;
        arr_last = vld_q && (idx_q == LAST_IDX);
    end

    AST_READ_PACED: assert property (@(posedge clk) disable iff (!rst_n)
        arr_we |-> ($past(rd_en) && arr_idx == $past(rd_word))); // R3

    AST_WORD_ORDER: assert property (@(posedge clk) disable iff (!rst_n)
        (arr_we && $past(arr_we)) |-> (arr_idx == WIDX_W'($past(arr_idx) + 1'b1))); // R2

    AST_DONE_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done); // R7

    AST_DONE_AFTER_LAST: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> ($past(arr_we) && $past(arr_idx) == LAST_IDX && !busy)); // R7

    AST_CTX_HELD: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && $past(busy)) |-> $stable(ctx_q)); // R6

endmodule

// File: rtl/ctx_switch_ctrl.sv
// Top of the context switch sequencer: contexts stored in a shared
// single-port RAM are copied word by word into the array on request, and
// host preload writes are arbitrated against the switch reads.
// Assumes: external RAM with one cycle of read latency, NUM_CTX*WPC words.
module ctx_switch_ctrl
    import ctxsw_pkg::*;
#(
    parameter  int NUM_CTX  = 16,
    parameter  int CFG_BITS = 5808,
    parameter  int WORD_W   = 32,
    localparam int WPC      = ctxsw_pkg::ceil_div(CFG_BITS, WORD_W),
    localparam int CTX_W    = (NUM_CTX > 1) ? $clog2(NUM_CTX) : 1,
    localparam int WIDX_W   = (WPC > 1) ? $clog2(WPC) : 1,
    localparam int ADDR_W   = (NUM_CTX * WPC > 1) ? $clog2(NUM_CTX * WPC) : 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              sw_req,
    input  logic [CTX_W-1:0]  sw_ctx,
    output logic              sw_busy,
    output logic              sw_done,
    input  logic              host_wr_valid,
    output logic              host_wr_ready,
    input  logic [CTX_W-1:0]  host_wr_ctx,
    input  logic [WIDX_W-1:0] host_wr_word,
    input  logic [WORD_W-1:0] host_wr_data,
    output logic              ram_en,
    output logic              ram_we,
    output logic [ADDR_W-1:0] ram_addr,
    output logic [WORD_W-1:0] ram_wdata,
    input  logic [WORD_W-1:0] ram_rdata,
    output logic              arr_we,
    output logic [WIDX_W-1:0] arr_idx,
    output logic [WORD_W-1:0] arr_data
);

    localparam int PAD_BITS = WPC * WORD_W - CFG_BITS;

    logic              start;
    logic              rd_en;
    logic [CTX_W-1:0]  rd_ctx;
    logic [WIDX_W-1:0] rd_word;
    logic [ADDR_W-1:0] rd_addr;
    logic [ADDR_W-1:0] host_addr;
    logic              arr_last;

    ctxsw_seq #(.WPC(WPC), .CTX_W(CTX_W), .WIDX_W(WIDX_W)) u_seq (
        .clk      (clk),
        .rst_n    (rst_n),
        .start    (start),
        .start_ctx(sw_ctx),
        .busy     (sw_busy),
        .done     (sw_done),
        .rd_en    (rd_en),
        .rd_ctx   (rd_ctx),
        .rd_word  (rd_word),
        .arr_we   (arr_we),
        .arr_idx  (arr_idx),
        .arr_last (arr_last)
    );

    ctxsw_addr_gen #(.WPC(WPC), .CTX_W(CTX_W), .WIDX_W(WIDX_W), .ADDR_W(ADDR_W)) u_rd_addr (
        .ctx (rd_ctx),
        .word(rd_word),
        .addr(rd_addr)
    );

    ctxsw_addr_gen #(.WPC(WPC), .CTX_W(CTX_W), .WIDX_W(WIDX_W), .ADDR_W(ADDR_W)) u_wr_addr (
        .ctx (host_wr_ctx),
        .word(host_wr_word),
        .addr(host_addr)
    );

    ctxsw_arbiter #(
        .NUM_CTX(NUM_CTX), .WPC(WPC), .WORD_W(WORD_W),
        .WIDX_W(WIDX_W), .ADDR_W(ADDR_W)
    ) u_arb (
        .clk       (clk),
        .rst_n     (rst_n),
        .busy      (sw_busy),
        .sw_req    (sw_req),
        .start     (start),
        .host_valid(host_wr_valid),
        .host_ready(host_wr_ready),
        .host_word (host_wr_word),
        .host_addr (host_addr),
        .host_data (host_wr_data),
        .rd_en     (rd_en),
        .rd_addr   (rd_addr),
        .ram_en    (ram_en),
        .ram_we    (ram_we),
        .ram_addr  (ram_addr),
        .ram_wdata (ram_wdata)
    );

    ctxsw_pad #(.WORD_W(WORD_W), .PAD_BITS(PAD_BITS)) u_pad (
        .is_last(arr_last),
        .din    (ram_rdata),
        .dout   (arr_data)
    );

endmodule

// File: tb/sim_ctx_switch_ctrl.sv
`timescale 1ns/1ps
// Scoreboard bench: switch driver pushes expected array words, a monitor
// pops and compares them as the design writes the array.
module sim_ctx_switch_ctrl;

    localparam int NCTX   = 4;
    localparam int CBITS  = 200;
    localparam int WW     = 32;
    localparam int WPC    = 7;              // ceil(200/32)
    localparam int CTXW   = 2;
    localparam int WIW    = 3;
    localparam int AW     = 5;
    localparam int DEPTH  = NCTX * WPC;
    localparam logic [WW-1:0] LAST_KEEP = 32'h0000_00FF; // 200-6*32 = 8 live bits

    logic            clk = 1'b0;
    logic            rst_n = 1'b0;
    logic            sw_req = 1'b0;
    logic [CTXW-1:0] sw_ctx = '0;
    logic            sw_busy, sw_done;
    logic            host_wr_valid = 1'b0;
    logic            host_wr_ready;
    logic [CTXW-1:0] host_wr_ctx = '0;
    logic [WIW-1:0]  host_wr_word = '0;
    logic [WW-1:0]   host_wr_data = '0;
    logic            ram_en, ram_we;
    logic [AW-1:0]   ram_addr;
    logic [WW-1:0]   ram_wdata;
    logic [WW-1:0]   ram_rdata = '0;
    logic            arr_we;
    logic [WIW-1:0]  arr_idx;
    logic [WW-1:0]   arr_data;

    int checks = 0;
    int fails  = 0;
    bit finished = 1'b0;

    logic [WW-1:0] mem     [DEPTH];
    logic [WW-1:0] exp_mem [DEPTH];
    int            q_idx[$];
    logic [WW-1:0] q_dat[$];

    always #4 clk = ~clk;   // 125 MHz

    ctx_switch_ctrl #(.NUM_CTX(NCTX), .CFG_BITS(CBITS), .WORD_W(WW)) u0 (
        .clk(clk), .rst_n(rst_n),
        .sw_req(sw_req), .sw_ctx(sw_ctx), .sw_busy(sw_busy), .sw_done(sw_done),
        .host_wr_valid(host_wr_valid), .host_wr_ready(host_wr_ready),
        .host_wr_ctx(host_wr_ctx), .host_wr_word(host_wr_word), .host_wr_data(host_wr_data),
        .ram_en(ram_en), .ram_we(ram_we), .ram_addr(ram_addr),
        .ram_wdata(ram_wdata), .ram_rdata(ram_rdata),
        .arr_we(arr_we), .arr_idx(arr_idx), .arr_data(arr_data)
    );

    // Single-port RAM model with one cycle of read latency
    initial for (int i = 0; i < DEPTH; i++) begin mem[i] = '0; exp_mem[i] = '0; end
    always @(posedge clk) begin
        if (ram_en) begin
            if (ram_we) mem[int'(ram_addr)] <= ram_wdata;
            else        ram_rdata <= mem[int'(ram_addr)];
        end
    end

    task automatic check(input bit ok, input string req, input string what,
                         input logic [WW-1:0] act, input logic [WW-1:0] exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
        end
    endtask

    function automatic logic [WW-1:0] pattern(input int c, input int w);
        return {8'h5A + 8'(c), 8'hF0 ^ 8'(w), 8'h3C, 8'h11 * 8'(w + 1)};
    endfunction

    // Monitor: every array write must match the head of the scoreboard (R3, R4)
    always @(negedge clk) begin
        if (rst_n && arr_we) begin
            if (q_idx.size() == 0) begin
                check(1'b0, "R3", "unexpected array write", {29'd0, arr_idx}, '0);
            end else begin
                int ei;
                logic [WW-1:0] ed;
                ei = q_idx.pop_front();
                ed = q_dat.pop_front();
                check(int'(arr_idx) == ei, "R2", "array word index", {29'd0, arr_idx}, WW'(ei));
                check(arr_data == ed, (ei == WPC-1) ? "R4" : "R3", "array word data", arr_data, ed);
            end
        end
    end

    // Host preload write with address check (R1) and range discard (R9)
    task automatic host_write(input int c, input int w, input logic [WW-1:0] d);
        @(posedge clk); #2;
        host_wr_valid = 1'b1;
        host_wr_ctx   = CTXW'(c);
        host_wr_word  = WIW'(w);
        host_wr_data  = d;
        do @(negedge clk); while (!host_wr_ready);
        if (w < WPC) begin
            check(ram_en && ram_we, "R1", "ram write strobe", {31'd0, ram_we}, 1);
            check(int'(ram_addr) == c * WPC + w, "R1", "ram write address",
                  {27'd0, ram_addr}, WW'(c * WPC + w));
        end else begin
            check(!ram_en, "R9", "out-of-range word touches ram", {31'd0, ram_en}, 0);
        end
        @(posedge clk); #2;
        host_wr_valid = 1'b0;
        if (w < WPC) exp_mem[c * WPC + w] = d;
    endtask

    // Switch driver: mode 0 plain, 1 request poke + held write mid-switch, 2 collision
    task automatic do_switch(input int c, input int mode);
        int  cnt;
        bit  pending;
        int  pw;
        logic [WW-1:0] pd;
        pending = 1'b0;
        pw = 2;
        pd = 32'hDEAD_0000 | WW'(c);
        do @(negedge clk); while (sw_busy);
        @(posedge clk); #2;
        sw_req = 1'b1;
        sw_ctx = CTXW'(c);
        for (int w = 0; w < WPC; w++) begin
            q_idx.push_back(w);
            q_dat.push_back((w == WPC-1) ? (exp_mem[c*WPC+w] & LAST_KEEP) : exp_mem[c*WPC+w]);
        end
        if (mode == 2) begin
            pending = 1'b1;
            pw = 0;
            host_wr_valid = 1'b1; host_wr_ctx = CTXW'(c);
            host_wr_word = WIW'(pw); host_wr_data = pd;
            @(negedge clk);
            check(!host_wr_ready, "R8", "host ready while switch requested", {31'd0, host_wr_ready}, 0);
        end
        @(posedge clk); #2;
        sw_req = 1'b0;
        cnt = 0;
        forever begin
            @(negedge clk);
            if (!sw_busy) break;
            cnt++;
            if (pending)
                check(!host_wr_ready, "R5", "host ready during switch", {31'd0, host_wr_ready}, 0);
            if (mode == 1 && cnt == 2) begin
                sw_req = 1'b1; sw_ctx = CTXW'(c ^ 1);
                pending = 1'b1;
                host_wr_valid = 1'b1; host_wr_ctx = CTXW'(c);
                host_wr_word = WIW'(pw); host_wr_data = pd;
            end
            if (mode == 1 && cnt == 3) sw_req = 1'b0;
            if (cnt > 4 * WPC) break;
        end
        check(cnt == WPC + 1, (mode == 1) ? "R6" : "R2", "busy length", WW'(cnt), WW'(WPC + 1));
        check(sw_done, "R7", "done with busy low", {31'd0, sw_done}, 1);
        check(q_idx.size() == 0, "R3", "words left unwritten", WW'(q_idx.size()), 0);
        if (pending) begin
            check(host_wr_ready, "R5", "held write released", {31'd0, host_wr_ready}, 1);
            @(posedge clk); #2;
            host_wr_valid = 1'b0;
            exp_mem[c * WPC + pw] = pd;
        end
        @(negedge clk);
        check(!sw_done, "R7", "done longer than one cycle", {31'd0, sw_done}, 0);
    endtask

    initial begin
        repeat (4) @(posedge clk);
        #2 rst_n = 1'b1;
        @(negedge clk);
        check(!sw_busy, "R10", "busy after reset", {31'd0, sw_busy}, 0);
        check(!sw_done, "R10", "done after reset", {31'd0, sw_done}, 0);
        check(!arr_we,  "R10", "array write after reset", {31'd0, arr_we}, 0);
        check(!ram_en,  "R10", "ram enable after reset", {31'd0, ram_en}, 0);
        check(host_wr_ready, "R10", "host ready after reset", {31'd0, host_wr_ready}, 1);

        for (int c = 0; c < NCTX; c++)
            for (int w = 0; w < WPC; w++)
                host_write(c, w, pattern(c, w));

        host_write(0, WPC, 32'hFFFF_FFFF);   // R9: would alias context 1 word 0
        do_switch(1, 0);                      // R9 seen through context 1 word 0
        do_switch(3, 1);                      // R6, R5
        do_switch(2, 2);                      // R8
        do_switch(0, 0);
        do_switch(3, 0);                      // held write from poke now visible
        do_switch(2, 0);                      // collided write now visible

        finished = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

    // Watchdog
    initial begin
        repeat (200000) @(posedge clk);
        if (!finished) begin
            checks++;
            fails++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
            $finish;
        end
    end

endmodule